// File: doc/BRIEF.md
# Magnetometer Two-Wire Slave Register Bank

This block is the two-wire serial (I2C) slave and register bank that sits next to a 3-axis magnetic sensor core. A host reaches it with a 7-bit device address: a fixed upper nibble plus a 3-bit strap code taken from pins. It first writes a one-byte register pointer. It can then write control bytes, or issue a repeated START and read a burst of registers. The pointer steps by one after every data byte. The bank holds the three 14-bit axis results, a status byte, two identification bytes and a set of factory placeholder locations.

On the core side, a parallel port loads new X/Y/Z words together with a strobe. Writes to the first control register raise single-cycle pulses toward the core: one to start a measurement, one to set the sensing film, and one to reset it. SCL and SDA enter as ordinary synchronous inputs. The block never drives SDA high: it only asserts an open-drain pull-down enable, and the pads are outside this block.

Top module: `magsens_i2c_regs`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 0110 followed by the strap code. Its least significant bit selects direction: 1 means read, 0 means write. For any other address it never pulls SDA low before the next START.
- R2: Registers 00h to 05h hold X, Y and Z in that order, low byte first and then high byte. Each value is 14-bit unsigned, and bits 7 to 6 of each high byte read as 0.
- R3: The status register 06h reads measurement-done in bit 0, the charge-pump input in bit 1 and the memory-read-done input in bit 2. Bits 7 to 3 read as 0.
- R4: A write to 07h gives a one-clock pulse on `meas_start` if data bit 0 is 1, on `set_pulse` if bit 5 is 1, and on `reset_pulse` if bit 6 is 1. Reads of 07h return 00h.
- R5: A write to 08h stores the byte on `ctrl1_q`, which resets to 00h. Reads of 08h return 00h.
- R6: Register 10h reads the strap code in bits 7 to 5 and zeros in the other bits. Register 20h reads 05h. Registers 1Ch to 1Fh and every other unmapped address read 00h, and writes to them have no effect.
- R7: The first data byte after a write address becomes the register pointer. Each later data byte, read or written, moves the pointer up by one, and the pointer wraps from FFh to 00h.
- R8: The slave pulls SDA low during the 9th SCL clock of every byte it accepts. It shifts read data out MSB first, and it changes its SDA drive only while SCL is low.
- R9: Measurement-done is cleared by a write of 1 to the take-measure bit (07h bit 0). It is set by the `data_valid` strobe and by nothing else.
- R10: Reading 00h copies all six axis bytes into a shadow copy. Reads of 01h to 05h return that shadow copy, so a burst that starts at 00h stays coherent even when new data arrives.
- R11: A master NACK after a read byte ends the burst, and the slave keeps SDA released until the next START. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_code | input | 3 | Strap code, the low three address bits |
| x_data | input | 14 | New X result |
| y_data | input | 14 | New Y result |
| z_data | input | 14 | New Z result |
| data_valid | input | 1 | One-cycle strobe that loads X/Y/Z and sets measurement-done |
| pump_on | input | 1 | Charge-pump status from the core |
| nvm_done | input | 1 | Memory-read-done status from the core |
| meas_start | output | 1 | One-cycle take-measurement pulse |
| set_pulse | output | 1 | One-cycle set pulse |
| reset_pulse | output | 1 | One-cycle reset pulse |
| ctrl1_q | output | 8 | Contents of control register 1 |

## Verification
The bench builds the block with a 14-bit axis width, a three-stage line synchronizer and strap code 3. With these values the device address is 33h, and 37h serves as a neighbouring address that must be refused. The longer synchronizer still resolves START, STOP and clock edges correctly at the bench's bus rate. The 14-bit width puts the all-ones value 3FFFh within reach, so the bench can confirm that the upper bits of each high byte are zero. The 8-bit pointer can be driven to FFh, so the bench checks the wrap into the X low byte, and the shadow latch that this wrap fires.

// File: rtl/magsens_pkg.sv
package magsens_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } bus_state_t;

  localparam logic [7:0] RA_STATUS = 8'h06;
  localparam logic [7:0] RA_CTRL0  = 8'h07;
  localparam logic [7:0] RA_CTRL1  = 8'h08;
  localparam logic [7:0] RA_ID0    = 8'h10;
  localparam logic [7:0] RA_ID1    = 8'h20;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_q;
      sda_d  <= sda_q;
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

  initial assert (STAGES >= 2) else $error("synchronizer needs two stages");
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import magsens_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [2:0] addr_code,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_first,
  output logic [7:0] wr_data,
  output logic       rd_req
);
  bus_state_t state;
  logic [2:0] bitcnt;
  logic [7:0] rx_sh, tx_sh;
  logic       is_addr, is_read, first_data;

  assign wr_stb   = (state == ST_RX_END) && scl_fall && !is_addr;
  assign wr_first = first_data;
  assign wr_data  = rx_sh;
  assign rd_req   = scl_fall && (((state == ST_RX_ACK) && is_read) || (state == ST_TX_NEXT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_addr    <= 1'b0;
      is_read    <= 1'b0;
      first_data <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      bitcnt  <= '0;
      is_addr <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: if (scl_rise) begin
          rx_sh  <= {rx_sh[6:0], sda_q};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) state <= ST_RX_END;
        end
        ST_RX_END: if (scl_fall) begin
          if (is_addr) begin
            if (rx_sh[7:1] == {ADDR_HI, addr_code}) begin
              sda_oe     <= 1'b1;
              is_read    <= rx_sh[0];
              first_data <= ~rx_sh[0];
              state      <= ST_RX_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            sda_oe     <= 1'b1;
            first_data <= 1'b0;
            state      <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          is_addr <= 1'b0;
          bitcnt  <= '0;
          if (is_read) begin
            tx_sh  <= rd_byte;
            sda_oe <= ~rd_byte[7];
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_TX_ACK;
          end else begin
            bitcnt <= bitcnt + 3'd1;
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end
        end
        ST_TX_ACK: if (scl_rise) begin
          state <= sda_q ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: if (scl_fall) begin
          tx_sh  <= rd_byte;
          sda_oe <= ~rd_byte[7];
          bitcnt <= '0;
          state  <= ST_TX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // SDA drive may only move while SCL is low (R8)
  assert_sda_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe));

  // after a master NACK the slave is released (R11)
  assert_nack_release_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/magsens_regbank.sv
module magsens_regbank
  import magsens_pkg::*;
#(
  parameter int         AXIS_W    = 14,
  parameter logic [7:0] ID1_VALUE = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              wr_first,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [2:0]        addr_code,
  input  logic [AXIS_W-1:0] x_data,
  input  logic [AXIS_W-1:0] y_data,
  input  logic [AXIS_W-1:0] z_data,
  input  logic              data_valid,
  input  logic              pump_on,
  input  logic              nvm_done,
  output logic [7:0]        rd_byte,
  output logic              meas_start,
  output logic              set_pulse,
  output logic              reset_pulse,
  output logic [7:0]        ctrl1_q
);
  localparam int NAXES = 3;
  localparam int PAD_W = 16 - AXIS_W;

  logic [AXIS_W-1:0] live   [NAXES];
  logic [AXIS_W-1:0] shadow [NAXES];
  logic [AXIS_W-1:0] new_in [NAXES];
  logic [7:0]        ptr;
  logic              meas_done;
  logic              go_meas;

  assign new_in[0] = x_data;
  assign new_in[1] = y_data;
  assign new_in[2] = z_data;
  assign go_meas   = wr_stb && !wr_first && (ptr == RA_CTRL0) && wr_data[0];

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (rst) begin
        live[a]   <= '0;
        shadow[a] <= '0;
      end else begin
        if (data_valid) live[a] <= new_in[a];
        if (rd_req && ptr == 8'h00) shadow[a] <= live[a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr         <= '0;
      ctrl1_q     <= '0;
      meas_start  <= 1'b0;
      set_pulse   <= 1'b0;
      reset_pulse <= 1'b0;
      meas_done   <= 1'b0;
    end else begin
      meas_start  <= 1'b0;
      set_pulse   <= 1'b0;
      reset_pulse <= 1'b0;
      if (wr_stb && wr_first) begin
        ptr <= wr_data;
      end else if (wr_stb) begin
        ptr <= ptr + 8'd1;
        if (ptr == RA_CTRL0) begin
          meas_start  <= wr_data[0];
          set_pulse   <= wr_data[5];
          reset_pulse <= wr_data[6];
        end
        if (ptr == RA_CTRL1) ctrl1_q <= wr_data;
      end else if (rd_req) begin
        ptr <= ptr + 8'd1;
      end
      if (go_meas)         meas_done <= 1'b0;
      else if (data_valid) meas_done <= 1'b1;
    end
  end

  function automatic logic [7:0] hi_byte(input logic [AXIS_W-1:0] v);
    logic [15:0] w;
    w = {{PAD_W{1'b0}}, v};
    return w[15:8];
  endfunction

  always_comb begin
    rd_byte = 8'h00;
    unique case (ptr)
      8'h00:     rd_byte = live[0][7:0];
      8'h01:     rd_byte = hi_byte(shadow[0]);
      8'h02:     rd_byte = shadow[1][7:0];
      8'h03:     rd_byte = hi_byte(shadow[1]);
      8'h04:     rd_byte = shadow[2][7:0];
      8'h05:     rd_byte = hi_byte(shadow[2]);
      RA_STATUS: rd_byte = {5'b0, nvm_done, pump_on, meas_done};
      RA_ID0:    rd_byte = {addr_code, 5'b0};
      RA_ID1:    rd_byte = ID1_VALUE;
      default:   rd_byte = 8'h00;
    endcase
  end

  // control pulses last one clock (R4)
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    (meas_start || set_pulse || reset_pulse) |=> !(meas_start && $past(meas_start))
      && !(set_pulse && $past(set_pulse)) && !(reset_pulse && $past(reset_pulse)));

  // measurement-done only rises after a core strobe (R9)
  assert_done_source_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_done) |-> $past(data_valid));

  // reads advance the pointer by exactly one (R7)
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ptr == $past(ptr) + 8'd1);

  initial assert (AXIS_W > 8 && AXIS_W <= 16) else $error("axis width out of range");
endmodule

// File: rtl/magsens_i2c_regs.sv
module magsens_i2c_regs #(
  parameter int         AXIS_W      = 14,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0110,
  parameter logic [7:0] ID1_VALUE   = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        addr_code,
  input  logic [AXIS_W-1:0] x_data,
  input  logic [AXIS_W-1:0] y_data,
  input  logic [AXIS_W-1:0] z_data,
  input  logic              data_valid,
  input  logic              pump_on,
  input  logic              nvm_done,
  output logic              meas_start,
  output logic              set_pulse,
  output logic              reset_pulse,
  output logic [7:0]        ctrl1_q
);
  logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb, wr_first, rd_req;
  logic [7:0] wr_data, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk(clk), .rst(rst), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_code(addr_code),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_data(wr_data), .rd_req(rd_req)
  );

  magsens_regbank #(.AXIS_W(AXIS_W), .ID1_VALUE(ID1_VALUE)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_data(wr_data), .rd_req(rd_req), .addr_code(addr_code),
    .x_data(x_data), .y_data(y_data), .z_data(z_data),
    .data_valid(data_valid), .pump_on(pump_on), .nvm_done(nvm_done),
    .rd_byte(rd_byte), .meas_start(meas_start), .set_pulse(set_pulse),
    .reset_pulse(reset_pulse), .ctrl1_q(ctrl1_q)
  );
endmodule

// File: tb/tb_magsens_i2c_regs.sv
module tb_magsens_i2c_regs;
  localparam int AW   = 14;
  localparam int HALF = 10;
  localparam logic [2:0] CODE = 3'd3;
  localparam logic [6:0] DEV  = {4'b0110, CODE};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [AW-1:0] xd = '0, yd = '0, zd = '0;
  logic dv = 1'b0, pump = 1'b0, nvm = 1'b0;
  logic ms, sp, rp;
  logic [7:0] c1;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  magsens_i2c_regs #(.AXIS_W(AW), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_code(CODE), .x_data(xd), .y_data(yd), .z_data(zd), .data_valid(dv),
    .pump_on(pump), .nvm_done(nvm), .meas_start(ms), .set_pulse(sp),
    .reset_pulse(rp), .ctrl1_q(c1)
  );

  int total = 0, fails = 0;
  int n_ms = 0, n_sp = 0, n_rp = 0, long_pulse = 0, hold_viol = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0, prev_ms = 1'b0;

  // behavioural reference state
  int ex[3], sx[3];
  bit done_m = 0;
  int ptr_m = 0;
  logic [7:0] wbuf[8];

  always @(negedge clk) begin
    if (!rst) begin
      if (ms) n_ms++;
      if (sp) n_sp++;
      if (rp) n_rp++;
      if (ms && prev_ms) long_pulse++;
      if (scl && prev_scl && sda_oe !== prev_oe) hold_viol++;
    end
    prev_scl = scl; prev_oe = sda_oe; prev_ms = ms;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int hib(input int v); return (v >> 8) & 8'h3F; endfunction

  function automatic int exp_reg(input int p);
    case (p)
      0: return ex[0] & 8'hFF;
      1: return hib(sx[0]);
      2: return sx[1] & 8'hFF;
      3: return hib(sx[1]);
      4: return sx[2] & 8'hFF;
      5: return hib(sx[2]);
      6: return {5'b0, nvm, pump, done_m};
      8'h10: return {CODE, 5'b0};
      8'h20: return 8'h05;
      default: return 0;
    endcase
  endfunction

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(HALF); scl = 1'b1; wait_n(HALF);
    sda_m = 1'b0; wait_n(HALF); scl = 1'b0; wait_n(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(HALF); scl = 1'b1; wait_n(HALF); sda_m = 1'b1; wait_n(HALF);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_n(HALF); scl = 1'b1; wait_n(HALF); scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_n(HALF); scl = 1'b1; wait_n(HALF/2); b = sda_bus;
    wait_n(HALF/2); scl = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask

  task automatic wr_regs(input int p, input int n);
    logic a;
    bus_start();
    send({DEV, 1'b0}, a); chk(a, "R8 address ack", a, 1);
    send(8'(p), a);       chk(a, "R8 pointer ack", a, 1);
    ptr_m = p;
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], a); chk(a, "R8 data ack", a, 1);
      if (ptr_m == 7 && wbuf[i][0]) done_m = 0;
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic rd_regs(input int p, input int n, input string req);
    logic a;
    logic [7:0] v;
    int e;
    bus_start();
    send({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
    send(8'(p), a);
    bus_start();
    send({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
    ptr_m = p;
    for (int i = 0; i < n; i++) begin
      if (ptr_m == 0) for (int k = 0; k < 3; k++) sx[k] = ex[k];
      e = exp_reg(ptr_m);
      recv(v, i == n - 1);
      chk(v == 8'(e), req, v, e);
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic load_data(input int x, input int y, input int z);
    xd = AW'(x); yd = AW'(y); zd = AW'(z); dv = 1'b1;
    wait_n(1); dv = 1'b0; wait_n(2);
    ex[0] = x; ex[1] = y; ex[2] = z; done_m = 1;
  endtask

  initial begin
    logic a;
    int m0, s0, r0, stuck;
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    chk(sda_oe == 1'b0, "R11 reset SDA released", sda_oe, 0);
    chk(c1 == 8'h00, "R5 reset ctrl1", c1, 0);
    chk({ms, sp, rp} == 3'b0, "R4 reset pulses", {ms, sp, rp}, 0);

    pump = 1'b1;
    load_data(14'h1234, 14'h3FFF, 14'h0001);
    rd_regs(6, 1, "R3 status after data");
    rd_regs(0, 6, "R2 axis burst");

    m0 = n_ms; s0 = n_sp; r0 = n_rp;
    wbuf[0] = 8'h01; wr_regs(7, 1);
    wait_n(4);
    chk(n_ms == m0 + 1, "R4 take-measure pulse", n_ms - m0, 1);
    chk(n_sp == s0 && n_rp == r0, "R4 no set/reset on 01h", n_sp - s0 + n_rp - r0, 0);
    rd_regs(6, 1, "R9 done cleared by take-measure");
    nvm = 1'b1;
    load_data(14'h0ABC, 14'h2001, 14'h1F0F);
    rd_regs(6, 1, "R9 done set by strobe");

    wbuf[0] = 8'h60; wr_regs(7, 1);
    wait_n(4);
    chk(n_sp == s0 + 1, "R4 set pulse", n_sp - s0, 1);
    chk(n_rp == r0 + 1, "R4 reset pulse", n_rp - r0, 1);
    chk(n_ms == m0 + 1, "R4 no take-measure on 60h", n_ms - m0, 1);
    rd_regs(7, 1, "R4 ctrl0 reads zero");

    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wr_regs(8, 2);
    chk(c1 == 8'hA5, "R5 ctrl1 stored", c1, 8'hA5);
    rd_regs(8, 2, "R6 ctrl1 and unmapped 09h read zero");
    rd_regs(8'h10, 1, "R6 id0 strap code");
    rd_regs(8'h1C, 4, "R6 factory placeholders");
    rd_regs(8'h20, 1, "R6 id1 constant");

    // shadow coherence: latch at 00h, then new data, then read 01h..05h
    rd_regs(0, 1, "R10 latch read");
    load_data(14'h0555, 14'h0666, 14'h0777);
    rd_regs(1, 5, "R10 shadow holds old data");
    rd_regs(0, 6, "R10 fresh burst");

    // pointer wrap FFh -> 00h
    rd_regs(8'hFF, 2, "R7 pointer wrap");

    // foreign address refused
    bus_start();
    send({4'b0110, 3'd7, 1'b0}, a);
    chk(a == 1'b0, "R1 foreign address not acked", a, 0);
    stuck = 0;
    for (int i = 0; i < 9; i++) begin put_bit(1'b1); if (sda_oe) stuck++; end
    chk(stuck == 0, "R1 SDA released after foreign address", stuck, 0);
    bus_stop();

    // NACK releases the bus
    rd_regs(2, 1, "R11 single byte then NACK");
    stuck = 0;
    for (int i = 0; i < 40; i++) begin wait_n(1); if (sda_oe) stuck++; end
    chk(stuck == 0, "R11 SDA idle after NACK", stuck, 0);

    chk(hold_viol == 0, "R8 SDA moved while SCL high", hold_viol, 0);
    chk(long_pulse == 0, "R4 pulse longer than one clock", long_pulse, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule